// File: doc/BRIEF.md
# PWM Audio Playback Ring

This block is a memory-mapped mono audio output. Software writes 8-bit unsigned samples into a 256-entry circular buffer over an AXI4-Lite slave port, then moves a head index forward to publish them. At a fixed 22 kHz rate the block takes the sample at its own tail index and advances that tail by one, wrapping at 256. The current sample sets the duty of a pulse-width modulated pin, which an external RC low-pass filter turns into an analog level. When the ring runs dry the pin idles at a 50 % duty (midscale), so the filtered output sits at its centre and makes no click.

A half-empty flag reports when half the ring or less is still waiting to be played. An interrupt pulse marks each moment the flag becomes set, so that a driver can refill in batches.

Three state machines make up the block. The write channel has states WR_IDLE and WR_RESP. WR_IDLE→WR_RESP happens when address and data are valid together. WR_RESP→WR_IDLE happens when the response is taken. The read channel has states RD_IDLE and RD_DATA. RD_IDLE→RD_DATA happens when a read address is accepted. RD_DATA→RD_IDLE happens when the data is taken. The player has states PL_SILENT and PL_PLAYING. On every sample tick it moves to PL_PLAYING if unplayed samples remain. Otherwise it moves to PL_SILENT.

Top module: `pwm_audio_ring`

## Requirements
- R1: A write is accepted in the cycle in which `s_awvalid` and `s_wvalid` are both high. Exactly one OKAY response (`s_bresp` = 0) follows and is held until `s_bready`. Read data and an OKAY `s_rresp` are held stable until `s_rready`.
- R2: A word-aligned write to an offset from 0x100 to 0x1FF stores each enabled byte lane i in ring entry (offset − 0x100) + i. Lane i is `s_wdata[8i+7:8i]` and is enabled by `s_wstrb[i]`. A word read there returns those four entries in the same lane order.
- R3: The head index is bits [7:0] at offset 0x200. A write with `s_wstrb[0]` set changes it, and a read returns it zero-extended. It resets to 0.
- R4: The tail index is bits [7:0] at offset 0x204. It resets to 0. Bus writes to it have no effect.
- R5: A sample tick occurs once every CLK_HZ/SAMPLE_HZ clock cycles. The first tick falls exactly that many cycles after reset is released.
- R6: On a tick with head ≠ tail, the entry at the tail becomes the current sample and the tail advances by one modulo 256. Samples therefore play in ring order, across the wrap from 255 to 0, and the tail never passes the head.
- R7: On a tick with head = tail, the current sample becomes 0x80 and the tail is unchanged. After reset the current sample is also 0x80.
- R8: `pwm_out` is driven by an 8-bit free-running carrier. In every 256 consecutive cycles with a constant sample value v, the pin is high for exactly v cycles, so 0x00 never goes high and 0xFF is high 255 of 256 cycles.
- R9: Bit 0 at offset 0x010 reads 1 exactly when (head − tail) mod 256 is 128 or less. Its other bits read 0.
- R10: `irq` is high for one cycle, two clock edges after each 0→1 change of the half-empty condition. It does not pulse when the flag falls, and it does not pulse out of reset.
- R11: Reads of any other offset, or of any address whose bits [1:0] are not zero, return 0. Writes to them change no readable state.
- R12: A head write accepted in the same cycle as a tick does not take part in that tick's decision. The tick sees the head value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address (window offset) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (window offset) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| pwm_out | output | 1 | PWM pin for the external RC filter |
| irq | output | 1 | One-cycle pulse when half-empty becomes set |

## Verification
The collision that matters is a head write from the bus landing on the same clock edge as a sample tick. One function publishes new samples while the other decides whether a sample can be consumed. The bench counts cycles from reset release and issues the head write so that its handshake falls exactly on the first tick edge, with the ring empty beforehand. The correct result is that the tail stays at 0 after that tick and reaches 1 only on the second tick. A design that let the fresh head reach the first tick would show a tail of 1 one tick early.

// File: rtl/pwm_audio_pkg.sv
`timescale 1ns/1ps
package pwm_audio_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned STRB_W     = DATA_W / 8;
    localparam int unsigned SAMPLE_W   = 8;
    localparam int unsigned STATUS_OFS = 'h010;
    localparam logic [SAMPLE_W-1:0] MIDSCALE = 8'h80;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_RESP = 1'b1
    } wr_state_t;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_DATA = 1'b1
    } rd_state_t;

    typedef enum logic {
        PL_SILENT  = 1'b0,
        PL_PLAYING = 1'b1
    } pl_state_t;

endpackage

// File: rtl/pwm_audio_buf.sv
`timescale 1ns/1ps
module pwm_audio_buf
    import pwm_audio_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic                clk,
    input  logic                we,
    input  logic [IDX_W-1:0]    widx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [STRB_W-1:0]   wstrb,
    input  logic [IDX_W-1:0]    ridx,
    output logic [DATA_W-1:0]   rword,
    input  logic [IDX_W-1:0]    pidx,
    output logic [SAMPLE_W-1:0] pbyte
);
    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam int unsigned LANE_W = $clog2(STRB_W);

    logic [SAMPLE_W-1:0] mem [DEPTH];

    // Lane writes into the ring storage; index low bits select the lane.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < STRB_W; i++) begin
                if (wstrb[i]) begin
                    mem[{widx[IDX_W-1:LANE_W], LANE_W'(i)}] <= wdata[8*i +: 8];
                end
            end
        end
    end

    // Word read port for the bus, byte read port for the player.
    for (genvar g = 0; g < STRB_W; g++) begin : g_lane
        assign rword[8*g +: 8] = mem[{ridx[IDX_W-1:LANE_W], LANE_W'(g)}];
    end

    assign pbyte = mem[pidx];

endmodule

// File: rtl/pwm_audio_bus.sv
`timescale 1ns/1ps
module pwm_audio_bus
    import pwm_audio_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned IDX_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                awvalid,
    output logic                awready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [STRB_W-1:0]   wstrb,
    input  logic                wvalid,
    output logic                wready,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic                arvalid,
    output logic                arready,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                rvalid,
    input  logic                rready,
    output logic                buf_we,
    output logic [IDX_W-1:0]    buf_widx,
    output logic [IDX_W-1:0]    buf_ridx,
    input  logic [DATA_W-1:0]   buf_rword,
    output logic [IDX_W-1:0]    head,
    input  logic [IDX_W-1:0]    tail,
    input  logic                half_empty
);
    localparam int unsigned REG_BASE = 2 << IDX_W;
    localparam int unsigned RGN_W    = ADDR_W - IDX_W;
    localparam logic [ADDR_W-1:0] OFS_HEAD = ADDR_W'(REG_BASE);
    localparam logic [ADDR_W-1:0] OFS_TAIL = ADDR_W'(REG_BASE + 4);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(STATUS_OFS);
    localparam logic [RGN_W-1:0]  RGN_BUF  = RGN_W'(1);

    wr_state_t wr_st, wr_nx;
    rd_state_t rd_st, rd_nx;

    logic              wr_fire, rd_fire;
    logic              aw_align, ar_align;
    logic [IDX_W-1:0]  head_q;
    logic [DATA_W-1:0] rd_mux, rdata_q;

    assign wr_fire  = (wr_st == WR_IDLE) && awvalid && wvalid;
    assign rd_fire  = (rd_st == RD_IDLE) && arvalid;
    assign aw_align = (awaddr[1:0] == 2'b00);
    assign ar_align = (araddr[1:0] == 2'b00);

    // ---------------- write channel ----------------
    always_comb begin
        wr_nx = wr_st;
        unique case (wr_st)
            WR_IDLE: if (awvalid && wvalid) wr_nx = WR_RESP;
            WR_RESP: if (bready)            wr_nx = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_st <= WR_IDLE;
        else        wr_st <= wr_nx;
    end

    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        unique case (wr_st)
            WR_IDLE: begin
                awready = awvalid && wvalid;
                wready  = awvalid && wvalid;
            end
            WR_RESP: bvalid = 1'b1;
        endcase
    end

    assign bresp    = 2'b00;
    assign buf_we   = wr_fire && aw_align && (awaddr[ADDR_W-1:IDX_W] == RGN_BUF);
    assign buf_widx = awaddr[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
        end else if (wr_fire && aw_align && (awaddr == OFS_HEAD) && wstrb[0]) begin
            head_q <= wdata[IDX_W-1:0];
        end
    end

    assign head = head_q;

    // ---------------- read channel ----------------
    always_comb begin
        rd_nx = rd_st;
        unique case (rd_st)
            RD_IDLE: if (arvalid) rd_nx = RD_DATA;
            RD_DATA: if (rready)  rd_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_st <= RD_IDLE;
        else        rd_st <= rd_nx;
    end

    always_comb begin
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (rd_st)
            RD_IDLE: arready = 1'b1;
            RD_DATA: rvalid  = 1'b1;
        endcase
    end

    assign buf_ridx = araddr[IDX_W-1:0];

    always_comb begin
        rd_mux = '0;
        if (ar_align) begin
            if (araddr[ADDR_W-1:IDX_W] == RGN_BUF) rd_mux = buf_rword;
            else if (araddr == OFS_HEAD)           rd_mux = DATA_W'(head_q);
            else if (araddr == OFS_TAIL)           rd_mux = DATA_W'(tail);
            else if (araddr == OFS_STAT)           rd_mux = DATA_W'(half_empty);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_fire) rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;
    assign rresp = 2'b00;

endmodule

// File: rtl/pwm_audio_player.sv
`timescale 1ns/1ps
module pwm_audio_player
    import pwm_audio_pkg::*;
#(
    parameter int unsigned DIV   = 300,
    parameter int unsigned IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    head,
    output logic [IDX_W-1:0]    tail,
    input  logic [SAMPLE_W-1:0] rd_byte,
    output logic [SAMPLE_W-1:0] level,
    output logic                half_empty,
    output logic                irq
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
    localparam logic [IDX_W-1:0] HALF     = IDX_W'(1 << (IDX_W - 1));

    pl_state_t pl_st, pl_nx;

    logic [CNT_W-1:0]    div_cnt;
    logic                tick, avail;
    logic [IDX_W-1:0]    tail_q, fill;
    logic [SAMPLE_W-1:0] held_q;
    logic                half_q, irq_q;

    // Sample-rate divider.
    assign tick = (div_cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    div_cnt <= '0;
        else if (tick) div_cnt <= '0;
        else           div_cnt <= div_cnt + 1'b1;
    end

    assign avail = (head != tail_q);

    // Player state machine: next state, state register, outputs.
    always_comb begin
        pl_nx = pl_st;
        if (tick) pl_nx = avail ? PL_PLAYING : PL_SILENT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pl_st <= PL_SILENT;
        else        pl_st <= pl_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail_q <= '0;
            held_q <= MIDSCALE;
        end else if (tick && avail) begin
            held_q <= rd_byte;
            tail_q <= tail_q + 1'b1;
        end
    end

    always_comb begin
        unique case (pl_st)
            PL_SILENT:  level = MIDSCALE;
            PL_PLAYING: level = held_q;
        endcase
    end

    assign tail = tail_q;

    // Occupancy flag and its rising-edge doorbell.
    assign fill       = head - tail_q;
    assign half_empty = (fill <= HALF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b1;
            irq_q  <= 1'b0;
        end else begin
            half_q <= half_empty;
            irq_q  <= half_empty && !half_q;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/pwm_audio_pwm.sv
`timescale 1ns/1ps
module pwm_audio_pwm
    import pwm_audio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] level,
    output logic                pwm_out
);
    logic [SAMPLE_W-1:0] carrier;
    logic                pwm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carrier <= '0;
            pwm_q   <= 1'b0;
        end else begin
            carrier <= carrier + 1'b1;
            pwm_q   <= (carrier < level);
        end
    end

    assign pwm_out = pwm_q;

endmodule

// File: rtl/pwm_audio_ring.sv
`timescale 1ns/1ps
module pwm_audio_ring
    import pwm_audio_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned SAMPLE_HZ = 22_000,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned IDX_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              pwm_out,
    output logic              irq
);
    localparam int unsigned DIV = CLK_HZ / SAMPLE_HZ;

    logic                buf_we;
    logic [IDX_W-1:0]    buf_widx, buf_ridx;
    logic [DATA_W-1:0]   buf_rword;
    logic [IDX_W-1:0]    head, tail;
    logic [SAMPLE_W-1:0] play_byte, level;
    logic                half_empty;

    pwm_audio_bus #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .awaddr     (s_awaddr),
        .awvalid    (s_awvalid),
        .awready    (s_awready),
        .wdata      (s_wdata),
        .wstrb      (s_wstrb),
        .wvalid     (s_wvalid),
        .wready     (s_wready),
        .bresp      (s_bresp),
        .bvalid     (s_bvalid),
        .bready     (s_bready),
        .araddr     (s_araddr),
        .arvalid    (s_arvalid),
        .arready    (s_arready),
        .rdata      (s_rdata),
        .rresp      (s_rresp),
        .rvalid     (s_rvalid),
        .rready     (s_rready),
        .buf_we     (buf_we),
        .buf_widx   (buf_widx),
        .buf_ridx   (buf_ridx),
        .buf_rword  (buf_rword),
        .head       (head),
        .tail       (tail),
        .half_empty (half_empty)
    );

    pwm_audio_buf #(.IDX_W(IDX_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (buf_widx),
        .wdata (s_wdata),
        .wstrb (s_wstrb),
        .ridx  (buf_ridx),
        .rword (buf_rword),
        .pidx  (tail),
        .pbyte (play_byte)
    );

    pwm_audio_player #(.DIV(DIV), .IDX_W(IDX_W)) u_player (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head),
        .tail       (tail),
        .rd_byte    (play_byte),
        .level      (level),
        .half_empty (half_empty),
        .irq        (irq)
    );

    pwm_audio_pwm u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (level),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_audio_ring_chk.sv
`timescale 1ns/1ps
module pwm_audio_ring_chk #(
    parameter int unsigned IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] head,
    input logic [IDX_W-1:0] tail,
    input logic             half_empty,
    input logic             irq,
    input logic [7:0]       level,
    input logic             pwm_out,
    input logic             s_bvalid,
    input logic             s_bready,
    input logic             s_rvalid,
    input logic             s_rready,
    input logic [31:0]      s_rdata
);
    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tail != $past(tail)) |-> (tail == IDX_W'($past(tail) + 1'b1))); // R6

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (tail != $past(tail)) |-> ($past(head) != $past(tail))); // R7

    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(half_empty) && !$past(half_empty, 2))); // R10

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R10

    AST_PWM_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_out |-> ($past(level) != 8'h00)); // R8

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid); // R1

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R1

endmodule

bind pwm_audio_ring pwm_audio_ring_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .head       (head),
    .tail       (tail),
    .half_empty (half_empty),
    .irq        (irq),
    .level      (level),
    .pwm_out    (pwm_out),
    .s_bvalid   (s_bvalid),
    .s_bready   (s_bready),
    .s_rvalid   (s_rvalid),
    .s_rready   (s_rready),
    .s_rdata    (s_rdata)
);

// File: tb/test_pwm_audio_ring.sv
`timescale 1ns/1ps
module test_pwm_audio_ring;

    localparam int unsigned SR   = 22_000;
    localparam int unsigned DIV  = 300;
    localparam int unsigned CLKF = SR * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b1;
    logic [11:0] s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b1;
    logic        s_pwm_out;
    logic        s_irq;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int irq_cnt = 0;

    always #2.5 clk = ~clk;

    pwm_audio_ring #(.CLK_HZ(CLKF), .SAMPLE_HZ(SR)) i_pwm_audio_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .pwm_out   (s_pwm_out),
        .irq       (s_irq)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst_n && s_irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // All bus tasks start and end just after a falling edge.
    task automatic axi_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] st);
        s_awaddr = a; s_wdata = d; s_wstrb = st;
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        #1;
        while (!(s_awready && s_wready)) begin @(negedge clk); #1; end
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        #1;
        check("R1", "write response valid", {31'b0, s_bvalid}, 32'd1);
        check("R1", "write response OKAY", {30'b0, s_bresp}, 32'd0);
        @(negedge clk);
    endtask

    task automatic axi_read(input logic [11:0] a, output logic [31:0] d);
        s_araddr = a; s_arvalid = 1'b1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(negedge clk);
        s_arvalid = 1'b0;
        #1;
        while (!s_rvalid) begin @(negedge clk); #1; end
        d = s_rdata;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        s_awvalid = 1'b0; s_wvalid = 1'b0; s_arvalid = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic measure_duty(output int hi);
        hi = 0;
        repeat (256) begin
            @(negedge clk);
            if (s_pwm_out) hi++;
        end
    endtask

    task automatic sync_tick(output logic [31:0] t);
        logic [31:0] t0;
        int guard = 0;
        axi_read(12'h204, t0);
        t = t0;
        while (t == t0 && guard < 1000) begin
            axi_read(12'h204, t);
            guard++;
        end
    endtask

    task automatic t_reset_and_regs();
        logic [31:0] d;
        int hi;
        do_reset();
        axi_read(12'h200, d); check("R3", "head after reset", d, 32'h0);
        axi_read(12'h204, d); check("R4", "tail after reset", d, 32'h0);
        axi_read(12'h010, d); check("R9", "half-empty after reset", d, 32'h1);
        check("R10", "no irq out of reset", 32'(irq_cnt), 32'd0);
        measure_duty(hi);     check("R7", "midscale duty after reset", 32'(hi), 32'd128);
        axi_write(12'h100, 32'hC0FFEE11, 4'hF);
        axi_read(12'h100, d);  check("R2", "ring word readback", d, 32'hC0FFEE11);
        axi_write(12'h104, 32'h01020304, 4'hF);
        axi_write(12'h104, 32'hAABBCCDD, 4'b0101);
        axi_read(12'h104, d);  check("R2", "partial lane write", d, 32'h01BB03DD);
        axi_write(12'h204, 32'h55, 4'hF);
        axi_read(12'h204, d);  check("R4", "tail ignores writes", d, 32'h0);
        axi_write(12'h020, 32'hFFFFFFFF, 4'hF);
        axi_write(12'h201, 32'h77, 4'hF);
        axi_read(12'h020, d);  check("R11", "unused offset reads zero", d, 32'h0);
        axi_read(12'h300, d);  check("R11", "offset above registers reads zero", d, 32'h0);
        axi_read(12'h201, d);  check("R11", "misaligned read is zero", d, 32'h0);
        axi_read(12'h200, d);  check("R11", "head untouched by stray writes", d, 32'h0);
        axi_write(12'h200, 32'h0, 4'h1);
        axi_read(12'h200, d);  check("R3", "head readback", d, 32'h0);
    endtask

    task automatic t_tick_period();
        logic [31:0] d;
        do_reset();
        axi_write(12'h200, 32'h1, 4'h1);
        while (cyc != DIV - 3) @(negedge clk);
        axi_read(12'h204, d); check("R5", "tail before first tick", d, 32'h0);
        while (cyc != DIV) @(negedge clk);
        axi_read(12'h204, d); check("R5", "tail after first tick", d, 32'h1);
    endtask

    task automatic t_coincide();
        logic [31:0] d;
        do_reset();
        while (cyc != DIV - 1) @(negedge clk);
        axi_write(12'h200, 32'h1, 4'h1);   // handshake lands on the tick edge
        axi_read(12'h204, d); check("R12", "tick used pre-write head", d, 32'h0);
        while (cyc < 2 * DIV + 2) @(negedge clk);
        axi_read(12'h204, d); check("R12", "next tick consumes sample", d, 32'h1);
    endtask

    task automatic t_order_and_half();
        logic [31:0] d, t, t2, hexp;
        logic [7:0] exp_s [4];
        int hi, snap, polls;
        do_reset();
        exp_s[0] = 8'h00; exp_s[1] = 8'hFF; exp_s[2] = 8'h40; exp_s[3] = 8'hC0;
        axi_write(12'h100, 32'hC040FF00, 4'hF);
        axi_write(12'h200, 32'h4, 4'h1);
        for (int k = 0; k < 4; k++) begin
            sync_tick(t);
            check("R6", "tail steps by one", t, 32'(k + 1));
            measure_duty(hi);
            check("R8", "duty equals ring entry", 32'(hi), 32'(exp_s[k]));
        end
        repeat (2 * DIV) @(negedge clk);
        axi_read(12'h204, d); check("R7", "tail stops at head", d, 32'h4);
        measure_duty(hi);     check("R7", "midscale when drained", 32'(hi), 32'd128);

        // Half-empty boundary and doorbell (within one sample period).
        axi_write(12'h200, 32'd204, 4'h1);
        sync_tick(t);
        axi_read(12'h010, d); check("R9", "fill 199 not half-empty", d, 32'h0);
        snap = irq_cnt;
        axi_write(12'h200, (t + 32'd128) & 32'hFF, 4'h1);
        axi_read(12'h010, d); check("R9", "fill 128 half-empty", d, 32'h1);
        check("R10", "irq on rise", 32'(irq_cnt - snap), 32'd1);
        axi_write(12'h200, (t + 32'd129) & 32'hFF, 4'h1);
        axi_read(12'h010, d); check("R9", "fill 129 not half-empty", d, 32'h0);
        check("R10", "no irq on fall", 32'(irq_cnt - snap), 32'd1);
        axi_write(12'h200, (t + 32'd128) & 32'hFF, 4'h1);
        axi_read(12'h010, d); check("R10", "second rise flag", d, 32'h1);
        check("R10", "irq on second rise", 32'(irq_cnt - snap), 32'd2);

        // Full-ring drain across the wrap.
        axi_read(12'h204, t2);
        hexp = (t2 - 32'd1) & 32'hFF;
        axi_write(12'h200, hexp, 4'h1);
        snap = irq_cnt;
        polls = 0;
        d = t2;
        while (d != hexp && polls < 300) begin
            repeat (DIV) @(negedge clk);
            axi_read(12'h204, d);
            polls++;
        end
        check("R6", "tail wraps to head", d, hexp);
        check("R10", "one irq during drain", 32'(irq_cnt - snap), 32'd1);
        axi_read(12'h010, d); check("R9", "empty ring half-empty", d, 32'h1);
        repeat (2 * DIV) @(negedge clk);
        axi_read(12'h204, d); check("R7", "tail holds when empty", d, hexp);
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset_and_regs();
        t_tick_period();
        t_coincide();
        t_order_and_half();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule